// File: doc/BRIEF.md
# Equalizer Boost Serial Configuration Port

This block is the configuration front end for a four-lane receive equalizer. A host loads settings through a three-wire serial port: an active-low enable, a serial clock and a data input. Each bit goes into a 21-bit shadow chain. When the enable returns high, the whole shadow chain is copied into the active bank. The active bank holds one override flag and one 5-bit boost word per lane. The last stage of the shadow chain drives a serial data output. Several ports can therefore share one enable and one clock and be loaded from a single stream.

Each lane also has three strap inputs that give a fallback boost code. While the override flag is clear, every lane uses the code decoded from its straps. While it is set, every lane uses its programmed word. A mode input gates the serial path. When mode is low, the shadow chain and the active bank are cleared and the straps take over.

The serial pins run far slower than the system clock `clk_i`. They are synchronized into that clock, and their edges are detected there. All results are registered in the system clock domain.

Top module: `eq_boost_cfg`

## Requirements
- R1: After reset the override output is 0, every lane's boost equals its strap code, and the serial output is 0.
- R2: Chain position p (1..21) is shadow bit p-1. Position 1 is the override flag. Lane k (0..3) takes positions 2+5k..6+5k, and the lowest of those positions is the LSB. Each sampled bit enters position 1 and moves up one position per later clock, so the host sends position 21 first and position 1 last.
- R3: Bits shifted while the enable is low do not change the outputs. The shadow chain is copied to the active bank only when the enable goes from low to high.
- R4: After the j-th accepted serial clock rise (j ≥ 21), the serial output shows the bit accepted at rise j-20. The serial output changes only after a rising serial clock edge.
- R5: If more than 21 bits arrive in one enable-low window, only the last 21 are kept.
- R6: An enable pulse with no serial clock rises leaves the outputs unchanged. Serial clock rises while the enable is high shift nothing.
- R7: While mode is low, the shadow chain and the active bank are held at zero and no shifting takes place. The straps then set every lane, even if mode falls in the middle of a transfer.
- R8: Strap decode. Pin a is 1 bit (0 = low, 1 = high). Pins b and c are 2-bit codes (0 = low, 1 = mid, 2 or 3 = high). With index i = 9a + 3b + c, the codes for i = 0..17 are 0,2,4,6,8,10,12,14,15,16,17,19,21,23,24,26,28,31.
- R9: With the override set, each lane outputs its programmed word. With it clear, each lane outputs its strap code.
- R10: On a commit, all four boost words move from old to new in the same system clock cycle.
- R11: Two ports in a chain, loaded with one 42-bit stream, end up with the first 21 bits in the far port and the last 21 bits in the near port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | High enables serial programming; low clears and selects straps |
| sen_ni | input | 1 | Serial enable, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (last chain stage) |
| pin_a_i | input | 4 | Strap MSB per lane |
| pin_b_i | input | 8 | Ternary middle strap per lane, 2 bits each |
| pin_c_i | input | 8 | Ternary LSB strap per lane, 2 bits each |
| ovr_o | output | 1 | Active override flag |
| boost_o | output | 20 | Lane boost words, lane k at bits 5k+4..5k |

## Verification
Each serial pin goes through a two-flop synchronizer, and edges are found on the synchronized signal. A shift therefore lands on the third system clock edge after a serial clock rise, and the serial output changes on that same edge. A commit writes the active bank on the third edge after the enable rises. The boost and override registers follow one edge later, and a strap change reaches the boost output one edge after it is applied. The bench keeps every serial clock phase 6 system cycles long. It samples the serial output at the end of the high phase, and it samples committed results 10 cycles after the enable rises, so every result is already settled when it is read. Simultaneity of the lane updates is checked on every cycle around a commit.

// File: rtl/eqcfg_pkg.sv
package eqcfg_pkg;
  typedef enum logic [1:0] {TRI_LOW = 2'd0, TRI_MID = 2'd1, TRI_HIGH = 2'd2} tri_e;

  function automatic tri_e to_tri(input logic [1:0] raw);
    case (raw)
      2'd0:    return TRI_LOW;
      2'd1:    return TRI_MID;
      default: return TRI_HIGH;
    endcase
  endfunction

  // 18-point strap ladder, index = 9*msb + 3*mid + lsb
  function automatic logic [4:0] strap_code(input logic [4:0] idx);
    case (idx)
      5'd0:  return 5'd0;
      5'd1:  return 5'd2;
      5'd2:  return 5'd4;
      5'd3:  return 5'd6;
      5'd4:  return 5'd8;
      5'd5:  return 5'd10;
      5'd6:  return 5'd12;
      5'd7:  return 5'd14;
      5'd8:  return 5'd15;
      5'd9:  return 5'd16;
      5'd10: return 5'd17;
      5'd11: return 5'd19;
      5'd12: return 5'd21;
      5'd13: return 5'd23;
      5'd14: return 5'd24;
      5'd15: return 5'd26;
      5'd16: return 5'd28;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/eqcfg_sync.sv
module eqcfg_sync #(
  parameter int  STAGES = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/eqcfg_strap_dec.sv
module eqcfg_strap_dec
  import eqcfg_pkg::*;
#(
  parameter int BW = 5
) (
  input  logic          msb_i,
  input  logic [1:0]    mid_i,
  input  logic [1:0]    lsb_i,
  output logic [BW-1:0] code_o
);
  tri_e       mid_t, lsb_t;
  logic [4:0] idx;

  always_comb begin
    mid_t  = to_tri(mid_i);
    lsb_t  = to_tri(lsb_i);
    idx    = (msb_i ? 5'd9 : 5'd0) + 5'(3 * int'(mid_t)) + 5'(int'(lsb_t));
    code_o = BW'(strap_code(idx));
  end

  always_comb begin
    assert_strap_range_R8: assert (idx <= 5'd17);
  end
endmodule

// File: rtl/eqcfg_chain.sv
module eqcfg_chain #(
  parameter int LEN = 21
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_i,
  input  logic           sen_ni,
  input  logic           sclk_i,
  input  logic           sdi_i,
  output logic           sdo_o,
  output logic           commit_o,
  output logic [LEN-1:0] active_o
);
  logic           sclk_d_q, sen_d_q;
  logic [LEN-1:0] shadow_q, active_q;
  logic           shift_en, commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      sen_d_q  <= 1'b1;
    end else begin
      sclk_d_q <= sclk_i;
      sen_d_q  <= sen_ni;
    end
  end

  assign shift_en = mode_i && !sen_ni && sclk_i && !sclk_d_q;
  assign commit   = mode_i && sen_ni && !sen_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else if (!mode_i) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shift_en) shadow_q <= {shadow_q[LEN-2:0], sdi_i};
      if (commit)   active_q <= shadow_q;
    end
  end

  assign sdo_o    = shadow_q[LEN-1];
  assign commit_o = commit;
  assign active_o = active_q;

  assert_active_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !(sen_ni && !sen_d_q)) |=> $stable(active_q));

  assert_mode_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (shadow_q == '0) && (active_q == '0));

  assert_no_shift_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && (sen_ni || !(sclk_i && !sclk_d_q))) |=> $stable(shadow_q));

  assert_sdo_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && shift_en) |=> sdo_o == $past(shadow_q[LEN-2]));
endmodule

// File: rtl/eq_boost_cfg.sv
module eq_boost_cfg #(
  parameter int LANES  = 4,
  parameter int BW     = 5,
  parameter int STAGES = 2,
  localparam int LEN   = 1 + LANES * BW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic                  sen_ni,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  input  logic [LANES-1:0]      pin_a_i,
  input  logic [2*LANES-1:0]    pin_b_i,
  input  logic [2*LANES-1:0]    pin_c_i,
  output logic                  ovr_o,
  output logic [LANES*BW-1:0]   boost_o
);
  logic mode_s, sen_s, sclk_s, sdi_s, commit;
  logic [LEN-1:0]      active;
  logic [LANES*BW-1:0] sel, boost_q;
  logic                ovr_q;

  eqcfg_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_mode (.clk_i, .rst_ni, .d_i(mode_i), .q_o(mode_s));
  eqcfg_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_sen  (.clk_i, .rst_ni, .d_i(sen_ni), .q_o(sen_s));
  eqcfg_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_sclk (.clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s));
  eqcfg_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_sdi  (.clk_i, .rst_ni, .d_i(sdi_i),  .q_o(sdi_s));

  eqcfg_chain #(.LEN(LEN)) u_chain (
    .clk_i, .rst_ni,
    .mode_i  (mode_s),
    .sen_ni  (sen_s),
    .sclk_i  (sclk_s),
    .sdi_i   (sdi_s),
    .sdo_o   (sdo_o),
    .commit_o(commit),
    .active_o(active)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BW-1:0] strap;
    eqcfg_strap_dec #(.BW(BW)) u_dec (
      .msb_i (pin_a_i[k]),
      .mid_i (pin_b_i[2*k +: 2]),
      .lsb_i (pin_c_i[2*k +: 2]),
      .code_o(strap)
    );
    assign sel[BW*k +: BW] = active[0] ? active[1 + BW*k +: BW] : strap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q   <= 1'b0;
      boost_q <= '0;
    end else begin
      ovr_q   <= active[0];
      boost_q <= sel;
    end
  end

  assign ovr_o   = ovr_q;
  assign boost_o = boost_q;

  assert_ovr_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(commit) |=> ovr_o == $past(active[0]));
endmodule

// File: tb/eq_boost_cfg_tb.sv
module eq_boost_cfg_tb;
  localparam int LANES = 4;
  localparam int BW    = 5;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, sen_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [LANES-1:0]    pa;
  logic [2*LANES-1:0]  pb, pc;
  logic sdo1, sdo2, ovr1, ovr2;
  logic [LANES*BW-1:0] b1, b2;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  eq_boost_cfg u_dut (.clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sen_ni(sen_n), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo1), .pin_a_i(pa), .pin_b_i(pb), .pin_c_i(pc), .ovr_o(ovr1), .boost_o(b1));
  eq_boost_cfg u_dut2 (.clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sen_ni(sen_n), .sclk_i(sclk),
    .sdi_i(sdo1), .sdo_o(sdo2), .pin_a_i('0), .pin_b_i('0), .pin_c_i('0), .ovr_o(ovr2), .boost_o(b2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ladder(input int i);
    int t[18] = '{0,2,4,6,8,10,12,14,15,16,17,19,21,23,24,26,28,31};
    return 5'(t[i]);
  endfunction

  function automatic int tval(input logic [1:0] r);
    return (r == 2'd0) ? 0 : (r == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [19:0] strap_exp();
    logic [19:0] r;
    for (int k = 0; k < LANES; k++)
      r[5*k +: 5] = ladder(9*int'(pa[k]) + 3*tval(pb[2*k +: 2]) + tval(pc[2*k +: 2]));
    return r;
  endfunction

  function automatic logic [20:0] mk(input logic o, input logic [4:0] w0, w1, w2, w3);
    return {w3, w2, w1, w0, o};
  endfunction

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic s);
    sdi = b; wcyc(HALF);
    sclk = 1'b1; wcyc(HALF);
    s = sdo1;
    sclk = 1'b0;
  endtask

  task automatic send_vec(input logic [20:0] v);
    logic s;
    for (int i = 20; i >= 0; i--) send_bit(v[i], s);
  endtask

  task automatic commit();
    wcyc(HALF); sen_n = 1'b1; wcyc(10);
  endtask

  task automatic t_reset();
    chk("R1 ovr", 32'(ovr1), 0);
    chk("R1 boost", 32'(b1), 32'(strap_exp()));
    chk("R1 sdo", 32'(sdo1), 0);
  endtask

  task automatic t_basic();
    logic [20:0] v = mk(1'b1, 5'd3, 5'd17, 5'd30, 5'd9);
    sen_n = 1'b0; wcyc(HALF);
    send_vec(v);
    wcyc(10);
    chk("R3 hold ovr", 32'(ovr1), 0);
    chk("R3 hold boost", 32'(b1), 32'(strap_exp()));
    commit();
    chk("R2 ovr", 32'(ovr1), 1);
    chk("R2 R9 boost", 32'(b1), 32'({5'd9, 5'd30, 5'd17, 5'd3}));
  endtask

  task automatic t_sdo_overlength();
    logic [41:0] s;
    logic [15:0] lf = 16'hACE1;
    logic o;
    for (int i = 0; i < 42; i++) begin
      s[i] = lf[0];
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end
    s[41] = 1'b1;
    sen_n = 1'b0; wcyc(HALF);
    for (int j = 1; j <= 42; j++) begin
      send_bit(s[j-1], o);
      if (j >= 21) chk("R4 sdo delay", 32'(o), 32'(s[j-21]));
    end
    commit();
    chk("R5 ovr last21", 32'(ovr1), 32'(s[41]));
    chk("R5 lane0 last21", 32'(b1[4:0]),
        32'({s[36], s[37], s[38], s[39], s[40]}));
    chk("R5 lane3 last21", 32'(b1[19:15]),
        32'({s[21], s[22], s[23], s[24], s[25]}));
  endtask

  task automatic t_straps();
    logic [20:0] v = mk(1'b0, 5'd7, 5'd7, 5'd7, 5'd7);
    sen_n = 1'b0; wcyc(HALF); send_vec(v); commit();
    chk("R9 ovr clear", 32'(ovr1), 0);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          pa[0] = a[0]; pb[1:0] = b[1:0]; pc[1:0] = c[1:0];
          wcyc(3);
          chk("R8 ladder", 32'(b1[4:0]), 32'(ladder(9*a + 3*(b > 2 ? 2 : b) + (c > 2 ? 2 : c))));
        end
    chk("R9 all lanes strap", 32'(b1), 32'(strap_exp()));
  endtask

  task automatic t_idle();
    logic [19:0] ob;
    logic oo, os;
    sen_n = 1'b0; wcyc(HALF); send_vec(mk(1'b1, 5'd1, 5'd2, 5'd4, 5'd8)); commit();
    ob = b1; oo = ovr1; os = sdo1;
    sen_n = 1'b0; wcyc(HALF); commit();
    chk("R6 pulse boost", 32'(b1), 32'(ob));
    chk("R6 pulse ovr", 32'(ovr1), 32'(oo));
    sdi = ~os;
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; wcyc(HALF); sclk = 1'b0; wcyc(HALF);
    end
    chk("R6 sclk idle sdo", 32'(sdo1), 32'(os));
    sen_n = 1'b0; wcyc(HALF); commit();
    chk("R6 sclk idle boost", 32'(b1), 32'(ob));
  endtask

  task automatic t_mode_drop();
    logic s;
    sen_n = 1'b0; wcyc(HALF);
    for (int i = 0; i < 10; i++) send_bit(1'b1, s);
    mode = 1'b0; wcyc(8);
    for (int i = 0; i < 5; i++) send_bit(1'b1, s);
    sen_n = 1'b1; wcyc(10);
    chk("R7 ovr", 32'(ovr1), 0);
    chk("R7 boost", 32'(b1), 32'(strap_exp()));
    chk("R7 sdo", 32'(sdo1), 0);
    mode = 1'b1; wcyc(8);
    sen_n = 1'b0; wcyc(HALF); commit();
    chk("R7 shadow cleared", 32'(ovr1), 0);
    chk("R7 shadow boost", 32'(b1), 32'(strap_exp()));
  endtask

  task automatic t_together();
    logic [19:0] ob, nb;
    int bad = 0;
    sen_n = 1'b0; wcyc(HALF); send_vec(mk(1'b1, 5'd21, 5'd22, 5'd23, 5'd24));
    ob = b1; nb = {5'd24, 5'd23, 5'd22, 5'd21};
    wcyc(HALF); sen_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (b1 !== ob && b1 !== nb) bad++;
    end
    chk("R10 split cycles", 32'(bad), 0);
    chk("R10 final", 32'(b1), 32'(nb));
  endtask

  task automatic t_chain();
    logic [20:0] v1 = mk(1'b1, 5'd5, 5'd6, 5'd7, 5'd29);
    logic [20:0] v2 = mk(1'b1, 5'd31, 5'd0, 5'd18, 5'd11);
    sen_n = 1'b0; wcyc(HALF);
    send_vec(v2); send_vec(v1);
    commit();
    chk("R11 near ovr", 32'(ovr1), 1);
    chk("R11 near boost", 32'(b1), 32'({5'd29, 5'd7, 5'd6, 5'd5}));
    chk("R11 far ovr", 32'(ovr2), 1);
    chk("R11 far boost", 32'(b2), 32'({5'd11, 5'd18, 5'd0, 5'd31}));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    pa = 4'b0110;
    pb = {2'd1, 2'd0, 2'd2, 2'd0};
    pc = {2'd2, 2'd0, 2'd2, 2'd0};
    wcyc(4); rst_n = 1'b1; wcyc(4);
    t_reset();
    mode = 1'b1; wcyc(6);
    t_basic();
    t_sdo_overlength();
    t_straps();
    t_idle();
    t_mode_drop();
    t_together();
    t_chain();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule